// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target end of a two-wire serial bus placed in front of a byte-wide memory. Its clock and data inputs arrive already synchronised to the system clock. The block watches them for start and stop conditions and checks the device address byte. It then loads a 16-bit word address and carries out byte writes, page writes, current-address reads, random reads and sequential reads. It answers on the data line through an open-drain pull enable. The bus itself supplies the high level.

A stop that closes a write opens a self-timed busy window. The window length is a parameter counted in system clocks. While the window is open the target is deaf to the bus, so a host learns that the write has finished by repeatedly sending an address byte until one is acknowledged. A write-protect input blocks every commit to the array. The array is an inferred RAM with `MEM_AW` address bits. Word addresses above its depth alias onto it. Setting `MEM_AW` to 16 gives the full 64 KiB made of 512 pages of 128 bytes.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A falling data line while the clock line is high is a start. A rising data line while the clock line is high is a stop. After reset, and in the clock after any stop, the pull enable is low and the target waits for a start.
- R2: The first byte after a start is 1,0,1,0,0, then `dev_sel_i[1]`, `dev_sel_i[0]`, then a read/write bit, sent MSB first. A mismatch is not acknowledged, and no later byte is acknowledged until the next start.
- R3: An acknowledge is a pull held low for the whole ninth clock of each accepted byte: the device byte, the high address byte, the low address byte and every write data byte.
- R4: During a write only the low 7 address bits advance after each data byte. Bytes past the end of a 128-byte page land at the start of the same page.
- R5: A read with no address phase returns the byte at the last accessed address plus one.
- R6: A write that carries only the two address bytes, followed by a repeated start and a read device byte, reads from the address just loaded.
- R7: During a read the whole 16-bit address advances after each byte, and it wraps from 0xFFFF to 0x0000.
- R8: A read continues while the host acknowledges. After a host non-acknowledge the target releases the data line and stays silent until the next start.
- R9: A stop that follows at least one unprotected data byte starts a busy window of `WR_CYCLES` clocks. During that window nothing is acknowledged, including address polls. After the window the target acknowledges again.
- R10: With `wp_i` high, bytes are still acknowledged, but the array is unchanged and no busy window starts.
- R11: The pull enable changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line (wired level) |
| dev_sel_i | input | 2 | Strapped low bits of the device address |
| wp_i | input | 1 | Write protect, high blocks commits |
| sda_pull_o | output | 1 | Open-drain enable, high pulls the data line low |

## Verification
The collision that matters is the last clock of the busy window landing in the same clock as a poll's start condition. It can also land partway through a poll's address byte. A start seen while busy is dropped, so that whole poll must go unanswered, and the next poll must be acknowledged. The bench polls back to back after every unprotected write. It then judges the result by the number of polls needed: two or three for a real write and exactly one for a protected write. A second overlap is the page wrap on the same clock that a data byte is committed. Random start offsets and lengths cross page ends, and the result is read back against a model array.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } tw_state_e;

  typedef enum logic [1:0] {
    FLD_DEV,
    FLD_AHI,
    FLD_ALO,
    FLD_DAT
  } tw_field_e;

  localparam logic [4:0] DEV_ID = 5'b10100;
endpackage

// File: rtl/tw_line_mon.sv
module tw_line_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              wr_step_i,
  input  logic              rd_step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] wr_next;

  generate
    if (PAGE_W < ADDR_W) begin : g_page
      assign wr_next = {addr_o[ADDR_W-1:PAGE_W], addr_o[PAGE_W-1:0] + PAGE_W'(1)};
    end else begin : g_flat
      assign wr_next = addr_o + ADDR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_o <= '0;
    else if (load_i)    addr_o <= load_val_i;
    else if (wr_step_i) addr_o <= wr_next;
    else if (rd_step_i) addr_o <= addr_o + ADDR_W'(1);
  end
endmodule

// File: rtl/tw_wr_timer.sv
module tw_wr_timer #(
  parameter int unsigned CYCLES = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (go_i)         cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import tw_pkg::*;
#(
  parameter int unsigned MEM_AW    = 11,
  parameter int unsigned PAGE_W    = 7,
  parameter int unsigned WR_CYCLES = 50000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] dev_sel_i,
  input  logic       wp_i,
  output logic       sda_pull_o
);
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DEPTH  = 1 << MEM_AW;

  logic scl_rise, scl_fall, start_det, stop_det;
  logic busy;

  tw_state_e st_q;
  tw_field_e fld_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] rx_sh_q, tx_sh_q, ahi_q;
  logic       pull_q, rd_mode_q, pend_q, host_ack_q;

  logic [ADDR_W-1:0] addr;
  logic [7:0] mem [DEPTH];
  logic [7:0] rd_byte;

  logic live, byte_done, dev_hit;
  logic addr_load, wr_step, rd_step, mem_we, wr_go;

  tw_line_mon u_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  // bus events only count when not busy and no framing condition this clock
  assign live      = ~busy & ~start_det & ~stop_det;
  assign byte_done = live & (st_q == ST_RX) & scl_fall & (bit_cnt_q == 4'd8);
  assign dev_hit   = (rx_sh_q[7:1] == {DEV_ID, dev_sel_i});
  assign addr_load = byte_done & (fld_q == FLD_ALO);
  assign wr_step   = byte_done & (fld_q == FLD_DAT);
  assign mem_we    = wr_step & ~wp_i;
  assign rd_step   = live & scl_fall &
                     (((st_q == ST_ACK) & (fld_q == FLD_DEV) & rd_mode_q) |
                      ((st_q == ST_RACK) & host_ack_q));
  assign wr_go     = ~busy & stop_det & pend_q;

  tw_addr_ctr #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (addr_load),
    .load_val_i ({ahi_q, rx_sh_q}),
    .wr_step_i  (wr_step),
    .rd_step_i  (rd_step),
    .addr_o     (addr)
  );

  tw_wr_timer #(
    .CYCLES (WR_CYCLES)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (wr_go),
    .busy_o (busy)
  );

  always_ff @(posedge clk_i) begin
    if (mem_we) mem[addr[MEM_AW-1:0]] <= rx_sh_q;
  end

  assign rd_byte = mem[addr[MEM_AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      fld_q      <= FLD_DEV;
      bit_cnt_q  <= '0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '0;
      ahi_q      <= '0;
      pull_q     <= 1'b0;
      rd_mode_q  <= 1'b0;
      pend_q     <= 1'b0;
      host_ack_q <= 1'b0;
    end else if (busy) begin
      st_q   <= ST_IDLE;
      pull_q <= 1'b0;
    end else if (start_det) begin
      st_q      <= ST_RX;
      fld_q     <= FLD_DEV;
      bit_cnt_q <= '0;
      pull_q    <= 1'b0;
    end else if (stop_det) begin
      st_q   <= ST_IDLE;
      pull_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && bit_cnt_q != 4'd8) begin
            rx_sh_q   <= {rx_sh_q[6:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            unique case (fld_q)
              FLD_DEV: begin
                if (dev_hit) begin
                  pull_q    <= 1'b1;
                  rd_mode_q <= rx_sh_q[0];
                  st_q      <= ST_ACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              FLD_AHI: begin
                ahi_q  <= rx_sh_q;
                pull_q <= 1'b1;
                st_q   <= ST_ACK;
              end
              FLD_ALO: begin
                pull_q <= 1'b1;
                st_q   <= ST_ACK;
              end
              default: begin
                if (!wp_i) pend_q <= 1'b1;
                pull_q <= 1'b1;
                st_q   <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt_q <= '0;
            pull_q    <= 1'b0;
            if (fld_q == FLD_DEV && rd_mode_q) begin
              tx_sh_q <= rd_byte;
              st_q    <= ST_TX;
            end else begin
              st_q <= ST_RX;
              unique case (fld_q)
                FLD_DEV: fld_q <= FLD_AHI;
                FLD_AHI: fld_q <= FLD_ALO;
                default: fld_q <= FLD_DAT;
              endcase
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt_q == 4'd7) begin
              st_q <= ST_RACK;
            end else begin
              tx_sh_q   <= {tx_sh_q[6:0], 1'b0};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) host_ack_q <= ~sda_i;
          if (scl_fall) begin
            if (host_ack_q) begin
              tx_sh_q   <= rd_byte;
              bit_cnt_q <= '0;
              st_q      <= ST_TX;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = pull_q | ((st_q == ST_TX) & ~tx_sh_q[7]);
endmodule

// File: rtl/tw_eeprom_chk.sv
module tw_eeprom_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              pull_i,
  input logic              busy_i,
  input logic              stop_i,
  input logic              mem_we_i,
  input logic              rd_step_i,
  input logic [ADDR_W-1:0] addr_i
);
  a_r11_pull_steady_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i)) |-> $stable(pull_i));

  a_r1_release_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !pull_i);

  a_r9_silent_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !pull_i);

  a_r9_busy_needs_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(stop_i));

  a_r4_page_row_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> (addr_i[ADDR_W-1:PAGE_W] == $past(addr_i[ADDR_W-1:PAGE_W])));

  a_r7_read_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_step_i |=> (addr_i == $past(addr_i) + ADDR_W'(1)));
endmodule

bind i2c_eeprom_target tw_eeprom_chk #(
  .ADDR_W (ADDR_W),
  .PAGE_W (PAGE_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .pull_i    (sda_pull_o),
  .busy_i    (busy),
  .stop_i    (stop_det),
  .mem_we_i  (mem_we),
  .rd_step_i (rd_step),
  .addr_i    (addr)
);

// File: tb/i2c_eeprom_target_test.sv
module i2c_eeprom_target_test;
  localparam int MAW   = 9;
  localparam int DEPTH = 1 << MAW;
  localparam int WRC   = 200;
  localparam int HP    = 4;
  localparam logic [7:0] DEV_W = 8'hA4;
  localparam logic [7:0] DEV_R = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic hsda = 1'b1;
  logic wp = 1'b0;
  logic [1:0] sel = 2'b10;
  logic pull;
  logic sda_line;

  assign sda_line = hsda & ~pull;

  always #10 clk = ~clk;

  i2c_eeprom_target #(
    .MEM_AW    (MAW),
    .PAGE_W    (7),
    .WR_CYCLES (WRC)
  ) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .dev_sel_i  (sel),
    .wp_i       (wp),
    .sda_pull_o (pull)
  );

  int errs = 0;
  int checks = 0;
  int r11_viol = 0;
  logic [7:0] model [DEPTH];
  logic [15:0] maddr = '0;

  logic scl_d = 1'b1, pull_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && scl_d && (pull !== pull_d)) r11_viol++;
    scl_d  <= scl;
    pull_d <= pull;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw();
    repeat (HP) @(negedge clk);
  endtask

  task automatic send_start();
    scl = 1'b0; hw();
    hsda = 1'b1; hw();
    scl = 1'b1; hw();
    hsda = 1'b0; hw();
    scl = 1'b0; hw();
  endtask

  task automatic send_stop();
    scl = 1'b0; hw();
    hsda = 1'b0; hw();
    scl = 1'b1; hw();
    hsda = 1'b1; hw();
  endtask

  task automatic put_bit(input bit b);
    hsda = b; hw();
    scl = 1'b1; hw();
    scl = 1'b0; hw();
  endtask

  task automatic get_bit(output bit b);
    hsda = 1'b1; hw();
    scl = 1'b1; hw();
    b = sda_line;
    scl = 1'b0; hw();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(x);
    ack = ~x;
  endtask

  task automatic recv_byte(input bit host_ack, output logic [7:0] v);
    bit x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      v[i] = x;
    end
    put_bit(~host_ack);
  endtask

  function automatic logic [15:0] page_step(input logic [15:0] a);
    return {a[15:7], a[6:0] + 7'd1};
  endfunction

  task automatic do_write(input logic [15:0] a, input int len, input bit prot);
    bit ack;
    logic [7:0] b;
    wp = prot;
    send_start();
    send_byte(DEV_W, ack); chk("R3 device ack", ack, 1);
    send_byte(a[15:8], ack); chk("R3 addr hi ack", ack, 1);
    send_byte(a[7:0], ack);  chk("R3 addr lo ack", ack, 1);
    maddr = a;
    for (int i = 0; i < len; i++) begin
      b = 8'($urandom);
      send_byte(b, ack);
      chk(prot ? "R10 data ack" : "R3 data ack", ack, 1);
      if (!prot) model[maddr % DEPTH] = b;
      maddr = page_step(maddr);
    end
    send_stop();
  endtask

  task automatic wait_ready(input bit prot);
    int n = 0;
    bit ack = 1'b0;
    while (!ack && n < 40) begin
      send_start();
      send_byte(DEV_W, ack);
      n++;
      if (!ack) send_stop();
    end
    send_stop();
    wp = 1'b0;
    if (prot) chk("R10 polls until ack", n, 1);
    else      chk("R9 polls until ack in 2..3", int'(n >= 2 && n <= 3), 1);
  endtask

  task automatic read_bytes(input int len, input string req);
    logic [7:0] v;
    for (int i = 0; i < len; i++) begin
      recv_byte(i != len - 1, v);
      chk(req, v, model[maddr % DEPTH]);
      maddr = maddr + 16'd1;
    end
    hw();
    chk("R8 released after host nack", pull, 0);
    send_stop();
  endtask

  task automatic do_read_rand(input logic [15:0] a, input int len, input string req);
    bit ack;
    send_start();
    send_byte(DEV_W, ack); chk("R6 dummy write device ack", ack, 1);
    send_byte(a[15:8], ack); chk("R6 addr hi ack", ack, 1);
    send_byte(a[7:0], ack);  chk("R6 addr lo ack", ack, 1);
    send_start();
    send_byte(DEV_R, ack); chk("R6 read device ack", ack, 1);
    maddr = a;
    read_bytes(len, req);
  endtask

  task automatic do_read_cur(input int len, input string req);
    bit ack;
    send_start();
    send_byte(DEV_R, ack); chk("R5 read device ack", ack, 1);
    read_bytes(len, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    bit ack;
    logic [15:0] a;
    int len;
    bit prot;
    void'($urandom(32'h5EED1234));
    repeat (5) @(negedge clk);
    chk("R1 reset pull released", pull, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", pull, 0);

    // fill the whole array, one full page per write
    for (int p = 0; p < DEPTH / 128; p++) begin
      do_write(16'(p * 128), 128, 1'b0);
      wait_ready(1'b0);
    end

    // R4: wrap inside a page
    do_write(16'h0178, 12, 1'b0);
    wait_ready(1'b0);
    do_read_cur(1, "R5 current address after wrapped write");
    do_read_rand(16'h0100, 8, "R4 wrapped bytes at page start");
    do_read_rand(16'h0178, 8, "R4 bytes at page end");

    // R7: counter wraps across 0xFFFF
    do_read_rand(16'hFFFE, 4, "R7 read across top of address space");
    do_read_cur(2, "R7 current address after wrap");

    // R2: mismatched device bytes
    send_start();
    send_byte(8'hA6, ack); chk("R2 wrong strap bits not acked", ack, 0);
    send_byte(8'h00, ack); chk("R2 later byte ignored", ack, 0);
    send_stop();
    send_start();
    send_byte(8'hB4, ack); chk("R2 wrong prefix not acked", ack, 0);
    send_stop();

    // R10: protected write leaves array unchanged
    do_write(16'h0040, 5, 1'b1);
    wait_ready(1'b1);
    do_read_rand(16'h0040, 5, "R10 array unchanged under protect");

    // random mix
    for (int t = 0; t < 12; t++) begin
      a    = 16'($urandom);
      len  = 1 + int'($urandom % 16);
      prot = ($urandom % 4) == 0;
      do_write(a, len, prot);
      wait_ready(prot);
      do_read_rand(16'($urandom), 1 + int'($urandom % 8), "R6 random read data");
    end

    chk("R11 pull changes while clock high", r11_viol, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule